// File: doc/BRIEF.md
# Signed Binary to Packed Decimal Converter

This block turns a 64-bit two's-complement integer into an 80-bit packed-decimal word that holds eighteen decimal digits and a sign. A caller presents the value and an external invalid indication together with a one-cycle start pulse. The block then runs a shift-and-add-three engine over the magnitude, one bit per clock. When the last bit has been shifted in, it registers the formatted result and pulses done.

Values whose magnitude needs more than eighteen digits cannot be encoded. The same holds for the most negative 64-bit value and for any request with the external invalid input asserted. Each of these produces a fixed indefinite word and sets the invalid flag, so no digits wrapped from a truncated magnitude ever reach the output. The result and the flag stay unchanged until the next conversion completes.

Top module: `dec_pack_conv`

## Requirements
- R1: While reset is high and after it is released, result_o is all zeros, invalid_o is 0 and done_o is 0 until the first conversion completes.
- R2: A start accepted while idle produces done_o high for exactly one cycle, 61 clock edges after the edge that sampled start_i (60 shift steps plus one formatting step).
- R3: On a valid result, bits [63:0] hold the sixteen least significant decimal digits of the magnitude, one digit per 4-bit nibble, with the least significant digit in bits [3:0].
- R4: On a valid result, digit 17 (counting from 1 at the least significant end) sits in bits [67:64], digit 18 sits in bits [71:68], and bits [78:72] are zero.
- R5: On a valid result, bit 79 is 1 when the input is negative and 0 when it is zero or positive; the digits always encode the absolute value.
- R6: If the absolute value is greater than 999999999999999999, invalid_o is 1 and result_o is the indefinite word: bits [79:64] = 16'hFFFF and bits [63:0] = 64'hC000000000000000.
- R7: The input 64'h8000000000000000 gives invalid_o = 1 and the indefinite word of R6.
- R8: When ext_invalid_i is high in the cycle that start_i is sampled, the output is the indefinite word with invalid_o = 1, whatever the value.
- R9: A start_i pulse that arrives while a conversion is running is ignored. The running conversion keeps its value, its result and its done timing.
- R10: result_o and invalid_o change only on the edge that raises done_o and stay stable in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request; sampled only while idle |
| value_i | input | 64 | Signed binary operand, sampled with start_i |
| ext_invalid_i | input | 1 | Forces the indefinite result, sampled with start_i |
| result_o | output | 80 | Packed decimal result: sign in bit 79, eighteen digit nibbles below it |
| invalid_o | output | 1 | Set when result_o holds the indefinite word |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The assertions rely on three things about the inputs: value_i and ext_invalid_i matter only in the cycle that start_i is sampled while idle; reset is synchronous; and start_i may arrive at any time, including during a conversion. The digit-carry check also relies on the front end zeroing any magnitude that is out of range, so the shift engine only ever sees values below ten to the eighteenth. The stimulus drives start_i for exactly one cycle and then waits for done_o. It breaks this pattern only once, with a second start in the middle of a conversion. Random operands are drawn in three bands: small, just within eighteen digits, and full 64-bit. Both signs are used and the external invalid input is set now and then, so every band reaches both the valid and the indefinite paths.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dpc_state_e;

  localparam int unsigned NIB_W = 4;

  // ten to the power n, evaluated at elaboration for limits and widths
  function automatic logic [63:0] pow10(input int unsigned n);
    logic [63:0] p;
    p = 64'd1;
    for (int i = 0; i < 64; i++) begin
      if (i < n) p = p * 64'd10;
    end
    return p;
  endfunction

  // true when every digit nibble of an 80-bit packed word is 0..9 and the pad is clear
  function automatic logic packed_ok(input logic [79:0] r);
    logic ok;
    ok = (r[78:72] == 7'd0);
    for (int i = 0; i < 18; i++) begin
      if (r[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/dpc_front.sv
module dpc_front #(
  parameter int unsigned W      = 64,
  parameter int unsigned DIGITS = 18,
  parameter int unsigned MAG_W  = 60
) (
  input  logic [W-1:0]     value_i,
  output logic             neg_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             over_o
);
  import dpc_pkg::*;

  localparam logic [W-1:0] LIMIT  = W'(pow10(DIGITS) - 64'd1);
  localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] abs_v;
  logic         is_min;
  logic         too_big;

  assign neg_o   = value_i[W-1];
  assign is_min  = (value_i == MINNEG);
  assign abs_v   = value_i[W-1] ? (~value_i + W'(1)) : value_i;
  assign too_big = (abs_v > LIMIT);
  assign over_o  = is_min | too_big;
  // out-of-range magnitudes are zeroed so the digit engine never overflows
  assign mag_o   = over_o ? '0 : abs_v[MAG_W-1:0];

endmodule

// File: rtl/dpc_digit_adj.sv
module dpc_digit_adj (
  input  logic [3:0] d_i,
  output logic [3:0] d_o
);
  always_comb begin
    if (d_i >= 4'd5) d_o = d_i + 4'd3;
    else             d_o = d_i;
  end
endmodule

// File: rtl/dpc_dabble.sv
module dpc_dabble #(
  parameter int unsigned MAG_W  = 60,
  parameter int unsigned DIGITS = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [MAG_W-1:0]      mag_i,
  output logic [4*DIGITS-1:0]   digits_o
);
  localparam int unsigned BCD_W = 4 * DIGITS;

  logic [MAG_W-1:0] src_q;
  logic [BCD_W-1:0] bcd_q;
  logic [BCD_W-1:0] adj;

  for (genvar g = 0; g < DIGITS; g++) begin : g_adj
    dpc_digit_adj u_adj (
      .d_i (bcd_q[g*4 +: 4]),
      .d_o (adj[g*4 +: 4])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      bcd_q <= '0;
    end else if (load_i) begin
      src_q <= mag_i;
      bcd_q <= '0;
    end else if (shift_i) begin
      src_q <= {src_q[MAG_W-2:0], 1'b0};
      bcd_q <= {adj[BCD_W-2:0], src_q[MAG_W-1]};
    end
  end

  assign digits_o = bcd_q;

  // R3: an in-range magnitude never carries out of the top digit
  no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    shift_i |-> (adj[BCD_W-1] == 1'b0));

endmodule

// File: rtl/dpc_pack.sv
module dpc_pack #(
  parameter int unsigned DIGITS = 18
) (
  input  logic [4*DIGITS-1:0] digits_i,
  input  logic                neg_i,
  input  logic                bad_i,
  output logic [79:0]         res_o
);
  localparam int unsigned LO_DIG = 16;
  localparam int unsigned HI_DIG = DIGITS - LO_DIG;
  localparam int unsigned PAD_W  = 15 - 4 * HI_DIG;
  localparam logic [79:0] INDEF  = {16'hFFFF, 64'hC000_0000_0000_0000};

  logic [15:0] hi_word;
  logic [63:0] lo_word;

  assign lo_word = digits_i[4*LO_DIG-1:0];
  assign hi_word = {neg_i, {PAD_W{1'b0}}, digits_i[4*DIGITS-1:4*LO_DIG]};
  assign res_o   = bad_i ? INDEF : {hi_word, lo_word};

endmodule

// File: rtl/dec_pack_conv.sv
module dec_pack_conv #(
  parameter int unsigned W      = 64,
  parameter int unsigned DIGITS = 18,
  localparam int unsigned RES_W = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [W-1:0]     value_i,
  input  logic             ext_invalid_i,
  output logic [RES_W-1:0] result_o,
  output logic             invalid_o,
  output logic             done_o
);
  import dpc_pkg::*;

  localparam int unsigned MAG_W = $clog2(pow10(DIGITS));
  localparam int unsigned CNT_W = $clog2(MAG_W);
  localparam logic [RES_W-1:0] INDEF = {16'hFFFF, 64'hC000_0000_0000_0000};

  dpc_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic sign_q, bad_q;

  logic             f_neg, f_over;
  logic [MAG_W-1:0] f_mag;
  logic [4*DIGITS-1:0] digits;
  logic [RES_W-1:0] packed_w;
  logic load, shift;

  dpc_front #(.W(W), .DIGITS(DIGITS), .MAG_W(MAG_W)) u_front (
    .value_i (value_i),
    .neg_o   (f_neg),
    .mag_o   (f_mag),
    .over_o  (f_over)
  );

  assign load  = (state_q == ST_IDLE) && start_i;
  assign shift = (state_q == ST_RUN);

  dpc_dabble #(.MAG_W(MAG_W), .DIGITS(DIGITS)) u_dabble (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .shift_i  (shift),
    .mag_i    (f_mag),
    .digits_o (digits)
  );

  dpc_pack #(.DIGITS(DIGITS)) u_pack (
    .digits_i (digits),
    .neg_i    (sign_q),
    .bad_i    (bad_q),
    .res_o    (packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sign_q    <= 1'b0;
      bad_q     <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sign_q  <= f_neg;
            bad_q   <= f_over | ext_invalid_i;
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt_q == CNT_W'(MAG_W - 1)) state_q <= ST_FIN;
          else                            cnt_q   <= cnt_q + CNT_W'(1);
        end
        ST_FIN: begin
          result_o  <= packed_w;
          invalid_o <= bad_q;
          done_o    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  indef_word_chk: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> (result_o == INDEF));

  // R4
  valid_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !invalid_o) |-> packed_ok(result_o));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(invalid_o)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && start_i) |=> (state_q != ST_IDLE));

endmodule

// File: tb/dec_pack_conv_tb.sv
`timescale 1ns/1ps
module dec_pack_conv_tb;

  localparam int LAT = 61;
  localparam logic [63:0] LIM = 64'd999999999999999999;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [63:0] value_i = '0;
  logic ext_invalid_i = 1'b0;
  logic [79:0] result_o;
  logic invalid_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dec_pack_conv u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i),
    .ext_invalid_i(ext_invalid_i), .result_o(result_o),
    .invalid_o(invalid_o), .done_o(done_o)
  );

  function automatic logic [80:0] expect_of(input logic [63:0] v, input logic e);
    logic neg;
    logic [63:0] a, lo;
    logic [15:0] hi;
    neg = v[63];
    if (e || v == 64'h8000_0000_0000_0000) return {1'b1, 16'hFFFF, 64'hC000_0000_0000_0000};
    a = neg ? (64'd0 - v) : v;
    if (a > LIM) return {1'b1, 16'hFFFF, 64'hC000_0000_0000_0000};
    lo = '0;
    for (int i = 0; i < 16; i++) begin
      lo = lo | ((a % 64'd10) << (4 * i));
      a = a / 64'd10;
    end
    hi = {neg, 7'd0, 4'((a / 64'd10) % 64'd10), 4'(a % 64'd10)};
    return {1'b0, hi, lo};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [80:0] act, input logic [80:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_conv(input logic [63:0] v, input logic e, input string tag, input bit poke);
    logic [80:0] exp;
    int cyc;
    exp = expect_of(v, e);
    @(negedge clk);
    start_i = 1'b1; value_i = v; ext_invalid_i = e;
    @(negedge clk);
    start_i = 1'b0; value_i = ~v; ext_invalid_i = ~e;
    cyc = 0;
    while (!done_o && cyc < 200) begin
      // R9: a second request in the middle of a run
      if (poke && cyc == 10) begin start_i = 1'b1; value_i = 64'd42; ext_invalid_i = 1'b1; end
      else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check(cyc == LAT, "R2 latency", 81'(cyc), 81'(LAT));
    check({invalid_o, result_o} === exp, tag, {invalid_o, result_o}, exp);
    @(negedge clk);
    check(!done_o, "R2 pulse width", 81'(done_o), 81'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [80:0] held;
    logic [63:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    check({invalid_o, done_o, result_o} === 82'd0, "R1 reset", {invalid_o, result_o}, 81'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check({invalid_o, done_o, result_o} === 82'd0, "R1 after reset", {invalid_o, result_o}, 81'd0);

    run_conv(64'd0, 1'b0, "R5 zero", 1'b0);
    run_conv(64'd7, 1'b0, "R3 one digit", 1'b0);
    run_conv(64'd1234567890123456, 1'b0, "R3 sixteen digits", 1'b0);
    run_conv(64'd987654321098765432, 1'b0, "R4 high digits", 1'b0);
    run_conv(LIM, 1'b0, "R4 largest", 1'b0);
    run_conv(64'd0 - LIM, 1'b0, "R5 most negative valid", 1'b0);
    run_conv(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5 minus one", 1'b0);
    run_conv(LIM + 64'd1, 1'b0, "R6 just over", 1'b0);
    run_conv(64'd0 - LIM - 64'd1, 1'b0, "R6 negative over", 1'b0);
    run_conv(64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R6 max positive", 1'b0);
    run_conv(64'h8000_0000_0000_0000, 1'b0, "R7 min value", 1'b0);
    run_conv(64'd5, 1'b1, "R8 external invalid", 1'b0);
    run_conv(64'd0, 1'b1, "R8 external invalid zero", 1'b0);
    run_conv(64'd31415926535, 1'b0, "R9 start while busy", 1'b1);

    // R10: outputs hold while idle with inputs changing
    held = {invalid_o, result_o};
    for (int k = 0; k < 8; k++) begin
      value_i = {$urandom(), $urandom()};
      ext_invalid_i = k[0];
      @(negedge clk);
    end
    check({invalid_o, result_o} === held, "R10 hold", {invalid_o, result_o}, held);

    for (int n = 0; n < 150; n++) begin
      case ($urandom_range(2, 0))
        0: v = 64'($urandom_range(99999, 0));
        1: v = {$urandom(), $urandom()} % (LIM + 64'd1);
        default: v = {$urandom(), $urandom()};
      endcase
      if ($urandom_range(1, 0) == 1) v = 64'd0 - v;
      run_conv(v, ($urandom_range(15, 0) == 0), "R3 R5 R6 random", 1'b0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule